// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Range Clamp

This unit is the arithmetic stage of a small fixed-point signal-processing datapath. Each transfer carries two 16-bit two's complement operands, a 3-bit operation code and a pair of bounds. The unit computes one result and holds it in an output register until the consumer takes it. The operations are: wrapping add and subtract, saturating subtract, saturating magnitude, saturating magnitude of a difference and bit reversal. Two clamp operations limit values to an upper and a lower bound. One clamps a single value. The other clamps two values packed into one 32-bit word.

Both edges use valid/ready. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, the result register is frozen and `in_ready` is low, so back-pressure reaches the producer in the same cycle. When `out_ready` is high, a new operation can be taken in the same cycle that the old result leaves, so the unit sustains one operation per clock.

For the packed clamp, the 32-bit word is formed as {`op_b`, `op_a`}: `op_a` is the even-addressed low lane and `op_b` is the high lane. Both lanes are clamped against the same bounds, and the clamped pair appears on all 32 bits of `res`.

Top module: `sat_arith_unit`

## Requirements
- R1: Code 0 gives `op_a + op_b` and code 1 gives `op_a - op_b`, both modulo 2^16 in `res[15:0]`. For every code other than 7, `res[31:16]` is zero.
- R2: Code 2 gives `op_a - op_b` saturated to the signed 16-bit range: 0x7FFF on positive overflow, 0x8000 on negative overflow, the exact difference otherwise.
- R3: Code 3 gives the magnitude of `op_a` saturated to 0x7FFF, so 0x8000 gives 0x7FFF. The result is never negative.
- R4: Code 4 gives the magnitude of the exact 17-bit difference `op_a - op_b`, limited to 0x7FFF.
- R5: Code 5 gives `op_a` with its bit order reversed: `res[i]` equals `op_a[15-i]`.
- R6: Code 6 clamps `op_a` with signed comparisons. If `op_a > hi_bound` the result is `hi_bound`. Otherwise, if `op_a < lo_bound` the result is `lo_bound`. Otherwise the result is `op_a`. The upper test takes precedence, so `hi_bound` wins when the bounds are inverted.
- R7: Code 7 applies the R6 clamp separately to the low lane `op_a` (result in `res[15:0]`) and to the high lane `op_b` (result in `res[31:16]`). No value crosses between lanes.
- R8: An operation is taken when `in_valid && in_ready` at a clock edge, and `out_valid` is high after that edge with the result on `res`. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `res` and `out_valid` stay unchanged.
- R10: A synchronous reset clears `res` to zero and `out_valid` to low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op | input | 3 | Operation code (0..7, see R1 to R7) |
| op_a | input | 16 | First operand, also the low packed lane |
| op_b | input | 16 | Second operand, also the high packed lane |
| hi_bound | input | 16 | Signed upper clamp bound |
| lo_bound | input | 16 | Signed lower clamp bound |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | 32 | Registered result |

## Verification
Each operation is tried with operands that put its result on both sides of a limit and exactly on it. Overflow in either direction tells the saturated subtract from the wrapping one. 0x8000 and the two extreme differences expose a magnitude that is computed too narrow. Asymmetric bit patterns catch a reversal that is mirrored incorrectly.

The clamp tests cover values above, below, inside and equal to the bounds, and also inverted bounds, which shows the order of the two comparisons. Packed words with one lane at -1 and the other positive show any borrow or mix-up between lanes. A stall with a second operation waiting, followed by a release, separates a held register from one that reloads too early. A reset asserted while an operation is offered must still leave the output cleared.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_SUBS   = 3'd2,
    OP_ABSS   = 3'd3,
    OP_ABSDS  = 3'd4,
    OP_BREV   = 3'd5,
    OP_CLAMP  = 3'd6,
    OP_CLAMP2 = 3'd7
  } sau_op_e;
endpackage

// File: rtl/sau_addsub_sat.sv
// Shared adder/subtractor with the saturating and magnitude variants.
module sau_addsub_sat #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_wrap,
  output logic [W-1:0] diff_wrap,
  output logic [W-1:0] diff_sat,
  output logic [W-1:0] abs_sat,
  output logic [W-1:0] absdiff_sat
);
  localparam int XW = W + 1;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [XW-1:0] ax, bx, sum_x, diff_x, abs_a_mag, abs_d_mag;

  // Clamp a (W+1)-bit signed value to the W-bit signed range.
  function automatic logic [W-1:0] clip_signed(input logic [XW-1:0] v);
    if (v[XW-1] != v[XW-2])
      return v[XW-1] ? NEG_MIN : POS_MAX;
    return v[W-1:0];
  endfunction

  // Magnitude of a (W+1)-bit signed value, read as unsigned.
  function automatic logic [XW-1:0] magnitude(input logic [XW-1:0] v);
    if (v[XW-1])
      return (~v) + {{(XW-1){1'b0}}, 1'b1};
    return v;
  endfunction

  // Limit an unsigned (W+1)-bit magnitude to the largest positive W-bit value.
  function automatic logic [W-1:0] clip_mag(input logic [XW-1:0] m);
    if (m[XW-1] || m[XW-2])
      return POS_MAX;
    return m[W-1:0];
  endfunction

  always_comb begin
    ax        = {a[W-1], a};
    bx        = {b[W-1], b};
    sum_x     = ax + bx;
    diff_x    = ax - bx;
    abs_a_mag = magnitude(ax);
    abs_d_mag = magnitude(diff_x);
  end

  assign sum_wrap    = sum_x[W-1:0];
  assign diff_wrap   = diff_x[W-1:0];
  assign diff_sat    = clip_signed(diff_x);
  assign abs_sat     = clip_mag(abs_a_mag);
  assign absdiff_sat = clip_mag(abs_d_mag);
endmodule

// File: rtl/sau_bitrev.sv
module sau_bitrev #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = x[W-1-i];
  end
endmodule

// File: rtl/sau_clamp_lane.sv
// One signed clamp lane; the upper bound is tested first.
module sau_clamp_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] y
);
  logic above, below;

  always_comb begin
    above = $signed(x) > $signed(hi);
    below = $signed(x) < $signed(lo);
    if (above)      y = hi;
    else if (below) y = lo;
    else            y = x;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sau_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      op,
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic [W-1:0]         hi_bound,
  input  logic [W-1:0]         lo_bound,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*W-1:0]       res
);
  localparam int LANES = 2;
  localparam int RW    = LANES * W;

  logic [W-1:0]  sum_wrap, diff_wrap, diff_sat, abs_sat, absdiff_sat, rev;
  logic [W-1:0]  lane_in  [LANES];
  logic [W-1:0]  lane_out [LANES];
  logic [RW-1:0] res_nxt;
  logic          take;

  sau_addsub_sat #(.W(W)) u_arith (
    .a(op_a), .b(op_b),
    .sum_wrap(sum_wrap), .diff_wrap(diff_wrap), .diff_sat(diff_sat),
    .abs_sat(abs_sat), .absdiff_sat(absdiff_sat)
  );

  sau_bitrev #(.W(W)) u_rev (.x(op_a), .y(rev));

  assign lane_in[0] = op_a;
  assign lane_in[1] = op_b;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sau_clamp_lane #(.W(W)) u_clamp (
      .x(lane_in[l]), .hi(hi_bound), .lo(lo_bound), .y(lane_out[l])
    );
  end

  always_comb begin
    res_nxt = '0;
    case (sau_op_e'(op))
      OP_ADD:    res_nxt[W-1:0] = sum_wrap;
      OP_SUB:    res_nxt[W-1:0] = diff_wrap;
      OP_SUBS:   res_nxt[W-1:0] = diff_sat;
      OP_ABSS:   res_nxt[W-1:0] = abs_sat;
      OP_ABSDS:  res_nxt[W-1:0] = absdiff_sat;
      OP_BREV:   res_nxt[W-1:0] = rev;
      OP_CLAMP:  res_nxt[W-1:0] = lane_out[0];
      OP_CLAMP2: res_nxt        = {lane_out[1], lane_out[0]};
      default:   res_nxt        = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else if (take) begin
      res       <= res_nxt;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_arith_unit_chk.sv
module sat_arith_unit_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     op,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   hi_bound,
  input logic [W-1:0]   lo_bound,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] res
);
  logic acc;
  assign acc = in_valid && in_ready && !rst;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    acc && op != 3'd7 |=> res[2*W-1:W] == '0);

  assert_abs_nonneg_R3: assert property (@(posedge clk) disable iff (rst)
    acc && op == 3'd3 |=> !res[W-1]);

  assert_rev_ends_R5: assert property (@(posedge clk) disable iff (rst)
    acc && op == 3'd5 |=> res[W-1] == $past(op_a[0]) && res[0] == $past(op_a[W-1]));

  assert_clamp_range_R6: assert property (@(posedge clk) disable iff (rst)
    acc && op == 3'd6 && $signed(hi_bound) >= $signed(lo_bound) |=>
      $signed(res[W-1:0]) <= $signed($past(hi_bound)) &&
      $signed(res[W-1:0]) >= $signed($past(lo_bound)));

  assert_take_valid_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  assert_empty_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(res));

  assert_stall_block_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !out_valid && res == '0);
endmodule

bind sat_arith_unit sat_arith_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .op_a(op_a), .hi_bound(hi_bound), .lo_bound(lo_bound),
  .out_valid(out_valid), .out_ready(out_ready), .res(res)
);

// File: tb/test_sat_arith_unit.sv
`timescale 1ns/1ps
module test_sat_arith_unit;
  logic        clk = 1'b0;
  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  op;
  logic [15:0] op_a, op_b, hi_bound, lo_bound;
  logic [31:0] res;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sat_arith_unit i_sat_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .op_a(op_a), .op_b(op_b), .hi_bound(hi_bound), .lo_bound(lo_bound),
    .out_valid(out_valid), .out_ready(out_ready), .res(res)
  );

  // {req, op, a, b, hi, lo, expected}
  localparam int NV = 29;
  localparam logic [102:0] VEC [NV] = '{
    {4'd1, 3'd0, 16'h7FFF, 16'h0001, 16'h0000, 16'h0000, 32'h00008000}, // R1 wrap
    {4'd1, 3'd0, 16'h1234, 16'h0F0F, 16'h0000, 16'h0000, 32'h00002143}, // R1
    {4'd1, 3'd1, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 32'h00007FFF}, // R1 wrap
    {4'd1, 3'd1, 16'h0005, 16'h0007, 16'h0000, 16'h0000, 32'h0000FFFE}, // R1
    {4'd2, 3'd2, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 32'h00008000}, // R2 neg sat
    {4'd2, 3'd2, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0000, 32'h00007FFF}, // R2 pos sat
    {4'd2, 3'd2, 16'h0100, 16'h0080, 16'h0000, 16'h0000, 32'h00000080}, // R2
    {4'd2, 3'd2, 16'hFFF0, 16'h0010, 16'h0000, 16'h0000, 32'h0000FFE0}, // R2
    {4'd3, 3'd3, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 32'h00007FFF}, // R3 most negative
    {4'd3, 3'd3, 16'hFFFB, 16'h0000, 16'h0000, 16'h0000, 32'h00000005}, // R3
    {4'd3, 3'd3, 16'h0042, 16'h0000, 16'h0000, 16'h0000, 32'h00000042}, // R3
    {4'd4, 3'd4, 16'h8000, 16'h7FFF, 16'h0000, 16'h0000, 32'h00007FFF}, // R4 -65535
    {4'd4, 3'd4, 16'h0003, 16'h000A, 16'h0000, 16'h0000, 32'h00000007}, // R4
    {4'd4, 3'd4, 16'h7FFF, 16'h8000, 16'h0000, 16'h0000, 32'h00007FFF}, // R4 +65535
    {4'd4, 3'd4, 16'hFFFE, 16'h0003, 16'h0000, 16'h0000, 32'h00000005}, // R4
    {4'd4, 3'd4, 16'hC000, 16'h4000, 16'h0000, 16'h0000, 32'h00007FFF}, // R4 exactly -32768
    {4'd5, 3'd5, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 32'h00008000}, // R5
    {4'd5, 3'd5, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 32'h00002C48}, // R5
    {4'd5, 3'd5, 16'hF000, 16'h0000, 16'h0000, 16'h0000, 32'h0000000F}, // R5
    {4'd6, 3'd6, 16'h00C8, 16'h0000, 16'h0064, 16'hFF9C, 32'h00000064}, // R6 above
    {4'd6, 3'd6, 16'hFF00, 16'h0000, 16'h0064, 16'hFF9C, 32'h0000FF9C}, // R6 below
    {4'd6, 3'd6, 16'h0032, 16'h0000, 16'h0064, 16'hFF9C, 32'h00000032}, // R6 inside
    {4'd6, 3'd6, 16'h0064, 16'h0000, 16'h0064, 16'hFF9C, 32'h00000064}, // R6 equal
    {4'd6, 3'd6, 16'h8000, 16'h0000, 16'h0064, 16'hFF9C, 32'h0000FF9C}, // R6 signed
    {4'd6, 3'd6, 16'h0005, 16'h0000, 16'h0000, 16'h0010, 32'h00000000}, // R6 inverted bounds
    {4'd7, 3'd7, 16'h00C8, 16'hFF00, 16'h0064, 16'hFF9C, 32'hFF9C0064}, // R7
    {4'd7, 3'd7, 16'h7FFF, 16'h0010, 16'h0064, 16'hFF9C, 32'h00100064}, // R7
    {4'd7, 3'd7, 16'hFFFF, 16'h0001, 16'h0064, 16'hFF9C, 32'h0001FFFF}, // R7 no borrow
    {4'd7, 3'd7, 16'h8000, 16'h7FFF, 16'h0064, 16'hFF9C, 32'h0064FF9C}  // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] h, input logic [15:0] l);
    op = o; op_a = a; op_b = b; hi_bound = h; lo_bound = l; in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    op = '0; op_a = '0; op_b = '0; hi_bound = '0; lo_bound = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && res == 32'h0, "R10 reset state", {31'b0, out_valid} | res, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 idle ready", {31'b0, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][98:96], VEC[i][95:80], VEC[i][79:64], VEC[i][63:48], VEC[i][47:32]);
      @(posedge clk);
      @(negedge clk);
      check(out_valid && res == VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][102:99], i),
            res, VEC[i][31:0]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drain", {31'b0, out_valid}, 32'h0);

    // Back-pressure: R9 hold, then R8 release
    out_ready = 1'b0;
    drive(3'd0, 16'h0001, 16'h0002, 16'h0000, 16'h0000);
    @(negedge clk);
    check(out_valid && res == 32'h3, "R8 first under stall", res, 32'h3);
    drive(3'd1, 16'h0010, 16'h0001, 16'h0000, 16'h0000);
    #0.5;
    check(in_ready == 1'b0, "R9 ready low", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    check(out_valid && res == 32'h3, "R9 held", res, 32'h3);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && res == 32'h0000000F, "R8 release", res, 32'h0000000F);
    in_valid = 1'b0;

    // Reset while an operation is offered
    drive(3'd3, 16'h8000, 16'h0000, 16'h0000, 16'h0000);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && res == 32'h0, "R10 reset over input",
          {31'b0, out_valid} | res, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule